// File: doc/BRIEF.md
# Three-Wire Serial Register Slave

This block is the configuration port of a display timing controller. A host reaches a small register file over a serial link with three wires: a serial clock, an active-low select and one data line that both ends share. Every frame is sixteen clocks long. It opens with a six-bit register address, then one direction flag and one spare clock. The last eight clocks carry a data byte, most significant bit first. On a write the spare clock is a filler bit that the slave does not use. On a read the spare clock is the turnaround: the host lets go of the line, and the slave drives the eight data bits that follow.

The register file has four registers. One is a scratch byte for link testing. One is a fixed identity byte. One holds a three-bit resolution code. The last holds a power bit and a bit that chooses who owns the configuration. When the host has not claimed ownership, the resolution output and the active/standby output come from strap pins, and reads of those fields show the strap values. Once the ownership bit is set, both outputs come from the registers.

The link pins are sampled in a system clock domain that runs much faster than the serial clock. Input bits are taken on rising serial clock edges. Read data is put on the line on falling edges, so the host can capture it on its next rising edge. The shared line appears at the ports as a data input, a data output and an output enable.

Top module: `tcon_spi_slave`

## Requirements
- R1: A frame is sent with select low. It carries 6 address bits MSB first, a direction bit (1 = read, 0 = write), one extra clock and 8 data bits MSB first. All bits are sampled on rising serial clock edges. A write takes effect only when its 16th rising edge is seen.
- R2: On a write, the value on the line during the extra clock (bit position 7 of the frame) is ignored.
- R3: On a read, the slave leaves the output enable low during the turnaround clock. It then drives the 8 register bits MSB first, each changing after a falling serial edge. The output enable is high only during those 8 data clocks.
- R4: Address 0x00 is an 8-bit scratch register that reads back exactly what was last written.
- R5: Address 0x01 reads as {CHIP_ID[3:0], CHIP_REV[3:0]}, and writes to it are ignored.
- R6: Address 0x02 keeps the resolution code in bits [2:0]. Codes: 7 = 800x480, 6 = 640x480, 5 = 480x272, 4 = 480x640, 1 = 480x272 dual-scan, 0 = 400x240 dual-scan. Bits [7:3] read as 0.
- R7: Address 0x03 bit 0 is the active enable (1 = active, 0 = standby). Bit 7 is the register-ownership bit. Bits [6:1] read as 0.
- R8: While the ownership bit is 0, `res_code` equals `strap_res` and `panel_active` equals `strap_active`. Reads of 0x02 bits [2:0] and of 0x03 bit 0 return those strap values.
- R9: While the ownership bit is 1, `res_code` and `panel_active` follow the stored register fields.
- R10: Raising select before the 16th clock drops the frame: no register changes, the output enable goes low and the next frame starts at bit 0.
- R11: Addresses 0x04 to 0x3F read as 0x00, and writes to them change no register.
- R12: After reset the scratch register is 0x00, the stored resolution is 7, the stored active bit is 0 and the ownership bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from the host, idle high |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_sdi | input | 1 | Value present on the shared data line |
| spi_sdo | output | 1 | Read data bit driven toward the shared line |
| spi_sdo_en | output | 1 | Drive enable for the shared data line |
| strap_res | input | 3 | Strapped resolution code |
| strap_active | input | 1 | Strapped active/standby level |
| res_code | output | 3 | Effective resolution code |
| panel_active | output | 1 | Effective active (1) / standby (0) |

## Verification
Two things can happen in the same cycle here. A write to the control register can flip the ownership bit while the strap pins are changing. Also, the end of a frame can meet the release of the drive enable. The bench moves the straps between frames in random order and writes the control register with the ownership bit both set and clear. Each time it compares both outputs, and the read-back of 0x02 and 0x03, against a model that picks the straps or the stored fields. Read frames check that the enable is low during the turnaround clock, high at every data sample, and low again once select rises. Frames cut off partway through must leave every register unchanged.

// File: rtl/tcon_spi_pkg.sv
package tcon_spi_pkg;

    localparam int ADDR_W      = 6;
    localparam int DATA_W      = 8;
    localparam int RES_W       = 3;
    localparam int DATA_START  = ADDR_W + 2;
    localparam int FRAME_BITS  = DATA_START + DATA_W;
    localparam int CNT_W       = $clog2(FRAME_BITS + 1);

    localparam logic [ADDR_W-1:0] A_SCRATCH = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_IDENT   = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_RES     = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(3);

    localparam logic [RES_W-1:0] RES_RESET = 3'd7;

    typedef struct packed {
        logic [DATA_W-1:0] scratch;
        logic [RES_W-1:0]  res;
        logic              owner;
        logic              active;
    } cfg_regs_t;

    function automatic logic [DATA_W-1:0] pack_res(input logic [RES_W-1:0] r);
        return {{(DATA_W-RES_W){1'b0}}, r};
    endfunction

    function automatic logic [DATA_W-1:0] pack_ctrl(input logic own, input logic act);
        return {own, {(DATA_W-2){1'b0}}, act};
    endfunction

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk_i,
    input  logic cs_n_i,
    input  logic sdi_i,
    output logic cs_act_o,
    output logic sdi_o,
    output logic rise_o,
    output logic fall_o
);
    // lane 0: sclk, lane 1: cs_n, lane 2: sdi
    localparam int LANES = 3;
    localparam logic [LANES-1:0] RST_VAL = 3'b010;

    logic [LANES-1:0] raw;
    logic [LANES-1:0] stg [STAGES];
    logic             sclk_prev;

    assign raw = {sdi_i, cs_n_i, sclk_i};

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= RST_VAL;
                else if (g == 0) stg[g] <= raw;
                else stg[g] <= stg[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) sclk_prev <= 1'b0;
        else     sclk_prev <= stg[STAGES-1][0];
    end

    assign cs_act_o = ~stg[STAGES-1][1];
    assign sdi_o    = stg[STAGES-1][2];
    assign rise_o   = stg[STAGES-1][0] & ~sclk_prev;
    assign fall_o   = ~stg[STAGES-1][0] & sclk_prev;
endmodule

// File: rtl/spi_frame_seq.sv
module spi_frame_seq
    import tcon_spi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_act,
    input  logic              rise,
    input  logic              fall,
    input  logic              sdi,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] addr,
    output logic              is_read,
    output logic [CNT_W-1:0]  bit_cnt,
    output logic              wr_pulse,
    output logic [DATA_W-1:0] wr_data,
    output logic              sdo,
    output logic              sdo_en
);
    localparam logic [CNT_W-1:0] C_DIR   = CNT_W'(ADDR_W);
    localparam logic [CNT_W-1:0] C_DATA  = CNT_W'(DATA_START);
    localparam logic [CNT_W-1:0] C_LAST  = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] C_END   = CNT_W'(FRAME_BITS);

    logic [DATA_W-1:0] rx_sh;
    logic [DATA_W-1:0] tx_sh;

    always_ff @(posedge clk) begin
        wr_pulse <= 1'b0;
        if (rst || !cs_act) begin
            bit_cnt <= '0;
            addr    <= '0;
            is_read <= 1'b0;
            rx_sh   <= '0;
            tx_sh   <= '0;
            sdo_en  <= 1'b0;
            if (rst) wr_data <= '0;
        end else begin
            if (rise && bit_cnt != C_END) begin
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt < C_DIR)   addr    <= {addr[ADDR_W-2:0], sdi};
                if (bit_cnt == C_DIR)  is_read <= sdi;
                if (bit_cnt >= C_DATA) rx_sh   <= {rx_sh[DATA_W-2:0], sdi};
                if (bit_cnt == C_LAST) begin
                    sdo_en <= 1'b0;
                    if (!is_read) begin
                        wr_pulse <= 1'b1;
                        wr_data  <= {rx_sh[DATA_W-2:0], sdi};
                    end
                end
            end
            if (fall && is_read) begin
                if (bit_cnt == C_DATA) begin
                    tx_sh  <= rd_data;
                    sdo_en <= 1'b1;
                end else if (sdo_en) begin
                    tx_sh  <= {tx_sh[DATA_W-2:0], 1'b0};
                end
            end
        end
    end

    assign sdo = tx_sh[DATA_W-1];
endmodule

// File: rtl/tcon_cfg_regs.sv
module tcon_cfg_regs
    import tcon_spi_pkg::*;
#(
    parameter logic [3:0] CHIP_ID  = 4'hA,
    parameter logic [3:0] CHIP_REV = 4'h2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_pulse,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [RES_W-1:0]  strap_res,
    input  logic              strap_active,
    output logic [DATA_W-1:0] rd_data,
    output logic [RES_W-1:0]  res_code,
    output logic              panel_active,
    output cfg_regs_t         regs
);
    always_ff @(posedge clk) begin
        if (rst) begin
            regs.scratch <= '0;
            regs.res     <= RES_RESET;
            regs.owner   <= 1'b0;
            regs.active  <= 1'b0;
        end else if (wr_pulse) begin
            case (wr_addr)
                A_SCRATCH: regs.scratch <= wr_data;
                A_RES:     regs.res     <= wr_data[RES_W-1:0];
                A_CTRL: begin
                    regs.owner  <= wr_data[DATA_W-1];
                    regs.active <= wr_data[0];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        res_code     = regs.owner ? regs.res    : strap_res;
        panel_active = regs.owner ? regs.active : strap_active;
    end

    always_comb begin
        case (rd_addr)
            A_SCRATCH: rd_data = regs.scratch;
            A_IDENT:   rd_data = {CHIP_ID, CHIP_REV};
            A_RES:     rd_data = pack_res(res_code);
            A_CTRL:    rd_data = pack_ctrl(regs.owner, panel_active);
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/tcon_spi_slave.sv
module tcon_spi_slave
    import tcon_spi_pkg::*;
#(
    parameter logic [3:0] CHIP_ID     = 4'hA,
    parameter logic [3:0] CHIP_REV    = 4'h2,
    parameter int         SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             spi_sclk,
    input  logic             spi_cs_n,
    input  logic             spi_sdi,
    output logic             spi_sdo,
    output logic             spi_sdo_en,
    input  logic [RES_W-1:0] strap_res,
    input  logic             strap_active,
    output logic [RES_W-1:0] res_code,
    output logic             panel_active
);
    logic              cs_act;
    logic              sdi_s;
    logic              sclk_rise;
    logic              sclk_fall;
    logic [ADDR_W-1:0] frm_addr;
    logic              frm_read;
    logic [CNT_W-1:0]  frm_cnt;
    logic              wr_pulse;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_data;
    cfg_regs_t         regs;

    spi_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .sclk_i   (spi_sclk),
        .cs_n_i   (spi_cs_n),
        .sdi_i    (spi_sdi),
        .cs_act_o (cs_act),
        .sdi_o    (sdi_s),
        .rise_o   (sclk_rise),
        .fall_o   (sclk_fall)
    );

    spi_frame_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .cs_act   (cs_act),
        .rise     (sclk_rise),
        .fall     (sclk_fall),
        .sdi      (sdi_s),
        .rd_data  (rd_data),
        .addr     (frm_addr),
        .is_read  (frm_read),
        .bit_cnt  (frm_cnt),
        .wr_pulse (wr_pulse),
        .wr_data  (wr_data),
        .sdo      (spi_sdo),
        .sdo_en   (spi_sdo_en)
    );

    tcon_cfg_regs #(.CHIP_ID(CHIP_ID), .CHIP_REV(CHIP_REV)) u_regs (
        .clk          (clk),
        .rst          (rst),
        .wr_pulse     (wr_pulse),
        .wr_addr      (frm_addr),
        .wr_data      (wr_data),
        .rd_addr      (frm_addr),
        .strap_res    (strap_res),
        .strap_active (strap_active),
        .rd_data      (rd_data),
        .res_code     (res_code),
        .panel_active (panel_active),
        .regs         (regs)
    );
endmodule

// File: rtl/tcon_spi_slave_chk.sv
module tcon_spi_slave_chk
    import tcon_spi_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cs_act,
    input logic              spi_sdo_en,
    input logic              frm_read,
    input logic [CNT_W-1:0]  frm_cnt,
    input logic              wr_pulse,
    input logic [ADDR_W-1:0] frm_addr,
    input logic [DATA_W-1:0] wr_data,
    input cfg_regs_t         regs,
    input logic [RES_W-1:0]  strap_res,
    input logic              strap_active,
    input logic [RES_W-1:0]  res_code,
    input logic              panel_active
);
    p_oe_window_r3: assert property (@(posedge clk) disable iff (rst)
        spi_sdo_en |-> (frm_read && frm_cnt >= CNT_W'(DATA_START)));

    p_oe_release_r10: assert property (@(posedge clk) disable iff (rst)
        !cs_act |=> !spi_sdo_en);

    p_scratch_store_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_pulse && frm_addr == A_SCRATCH) |=> regs.scratch == $past(wr_data));

    p_owner_store_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_pulse && frm_addr == A_CTRL) |=> regs.owner == $past(wr_data[DATA_W-1]));

    p_strap_follow_r8: assert property (@(posedge clk) disable iff (rst)
        !regs.owner |-> (res_code == strap_res && panel_active == strap_active));

    p_unmapped_write_r11: assert property (@(posedge clk) disable iff (rst)
        (wr_pulse && frm_addr > A_CTRL) |=> $stable(regs));
endmodule

bind tcon_spi_slave tcon_spi_slave_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .cs_act       (cs_act),
    .spi_sdo_en   (spi_sdo_en),
    .frm_read     (frm_read),
    .frm_cnt      (frm_cnt),
    .wr_pulse     (wr_pulse),
    .frm_addr     (frm_addr),
    .wr_data      (wr_data),
    .regs         (regs),
    .strap_res    (strap_res),
    .strap_active (strap_active),
    .res_code     (res_code),
    .panel_active (panel_active)
);

// File: tb/tcon_spi_slave_tb_top.sv
module tcon_spi_slave_tb_top;
    localparam int HALF = 8;
    localparam logic [3:0] ID  = 4'hA;
    localparam logic [3:0] REV = 4'h2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic spi_sclk = 1'b1;
    logic spi_cs_n = 1'b1;
    logic spi_sdi = 1'b0;
    logic spi_sdo, spi_sdo_en;
    logic [2:0] strap_res = 3'd5;
    logic strap_active = 1'b1;
    logic [2:0] res_code;
    logic panel_active;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // bench model
    logic [7:0] m_scratch = 8'h00;
    logic [2:0] m_res = 3'd7;
    logic m_owner = 1'b0;
    logic m_act = 1'b0;

    always #4 clk = ~clk;

    tcon_spi_slave #(.CHIP_ID(ID), .CHIP_REV(REV)) dut_i (
        .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_sdi(spi_sdi), .spi_sdo(spi_sdo), .spi_sdo_en(spi_sdo_en),
        .strap_res(strap_res), .strap_active(strap_active),
        .res_code(res_code), .panel_active(panel_active)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [5:0] a);
        case (a)
            6'd0: return m_scratch;
            6'd1: return {ID, REV};
            6'd2: return {5'b0, m_owner ? m_res : strap_res};
            6'd3: return {m_owner, 6'b0, m_owner ? m_act : strap_active};
            default: return 8'h00;
        endcase
    endfunction

    function automatic void model_write(input logic [5:0] a, input logic [7:0] d);
        case (a)
            6'd0: m_scratch = d;
            6'd2: m_res = d[2:0];
            6'd3: begin m_owner = d[7]; m_act = d[0]; end
            default: ;
        endcase
    endfunction

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // nbits < 16 gives an aborted frame
    task automatic frame(input logic [5:0] a, input bit rd, input bit pad,
                         input logic [7:0] wd, input int nbits,
                         output logic [7:0] rv, output bit oe_ok);
        rv = 8'h00;
        oe_ok = 1'b1;
        spi_cs_n = 1'b0;
        waitc(HALF);
        for (int i = 0; i < nbits; i++) begin
            spi_sclk = 1'b0;
            if (i < 6)       spi_sdi = a[5-i];
            else if (i == 6) spi_sdi = rd;
            else if (i == 7) spi_sdi = rd ? 1'b0 : pad;
            else             spi_sdi = rd ? 1'b0 : wd[15-i];
            waitc(HALF);
            if (rd && i == 7 && spi_sdo_en) oe_ok = 1'b0;
            if (rd && i >= 8) begin
                rv[15-i] = spi_sdo;
                if (!spi_sdo_en) oe_ok = 1'b0;
            end
            spi_sclk = 1'b1;
            waitc(HALF);
        end
        spi_sdi = 1'b0;
        waitc(HALF);
        spi_cs_n = 1'b1;
        waitc(2 * HALF);
    endtask

    task automatic do_write(input logic [5:0] a, input logic [7:0] d, input bit pad);
        logic [7:0] rv; bit ok;
        frame(a, 1'b0, pad, d, 16, rv, ok);
        model_write(a, d);
    endtask

    task automatic do_read(input logic [5:0] a, input string tag);
        logic [7:0] rv; bit ok;
        frame(a, 1'b1, 1'b0, 8'h00, 16, rv, ok);
        chk(rv == exp_read(a), tag, rv, exp_read(a));
        chk(ok, "R3 drive enable window", ok, 1);
        chk(!spi_sdo_en, "R3 enable released after read", spi_sdo_en, 0);
    endtask

    task automatic check_outputs(input string tag);
        logic [2:0] er;
        logic ea;
        er = m_owner ? m_res : strap_res;
        ea = m_owner ? m_act : strap_active;
        chk(res_code == er, tag, res_code, er);
        chk(panel_active == ea, tag, panel_active, ea);
    endtask

    initial begin
        logic [7:0] rv;
        bit ok;
        int unsigned seed;
        seed = $urandom(32'd20511);
        waitc(10);
        rst = 1'b0;
        waitc(4);

        // R12 reset state
        chk(!spi_sdo_en, "R12 enable idle after reset", spi_sdo_en, 0);
        check_outputs("R12 R8 outputs follow straps after reset");
        do_read(6'd0, "R12 scratch reset value");
        do_read(6'd3, "R12 control reset value");

        // R4 scratch, R1 frame, R2 pad bit
        do_write(6'd0, 8'h55, 1'b1);
        do_read(6'd0, "R4 scratch 0x55 readback");
        do_write(6'd0, 8'hA3, 1'b0);
        do_read(6'd0, "R1 R2 scratch write with pad 0");

        // R5 identity, writes ignored
        do_read(6'd1, "R5 identity byte");
        do_write(6'd1, 8'h00, 1'b1);
        do_read(6'd1, "R5 identity after write");

        // R11 unimplemented
        do_write(6'd40, 8'hFF, 1'b0);
        do_read(6'd40, "R11 unmapped reads zero");
        do_read(6'd0, "R11 scratch unchanged by unmapped write");
        do_read(6'd63, "R11 top address reads zero");

        // R8 hardware ownership: register write does not reach outputs
        do_write(6'd2, 8'hF9, 1'b0);
        check_outputs("R8 strap resolution while unowned");
        do_read(6'd2, "R8 res readback shows strap");
        strap_res = 3'd4; strap_active = 1'b0;
        waitc(2);
        check_outputs("R8 outputs track strap change");
        do_read(6'd3, "R8 control readback shows strap active");

        // R9 R6 R7 take ownership
        do_write(6'd3, 8'h80, 1'b0);
        check_outputs("R9 owned standby");
        do_read(6'd2, "R6 owned res readback bits 7:3 zero");
        do_write(6'd3, 8'hFF, 1'b0);
        check_outputs("R9 owned active");
        do_read(6'd3, "R7 control reads only bits 7 and 0");
        strap_res = 3'd0; strap_active = 1'b0;
        waitc(2);
        check_outputs("R9 straps ignored when owned");

        // R10 aborted write and read
        frame(6'd0, 1'b0, 1'b0, 8'h0F, 12, rv, ok);
        do_read(6'd0, "R10 aborted write leaves scratch");
        frame(6'd0, 1'b0, 1'b0, 8'h0F, 15, rv, ok);
        do_read(6'd0, "R10 write cut at bit 15 leaves scratch");
        frame(6'd1, 1'b1, 1'b0, 8'h00, 11, rv, ok);
        chk(!spi_sdo_en, "R10 enable dropped on abort", spi_sdo_en, 0);
        do_read(6'd1, "R10 frame after abort starts at bit 0");

        // random mix
        for (int k = 0; k < 50; k++) begin
            logic [5:0] a;
            logic [7:0] d;
            int pick;
            pick = int'($urandom % 6);
            a = (pick < 4) ? 6'(pick) : 6'($urandom % 64);
            d = 8'($urandom);
            if ($urandom % 4 == 0) begin
                strap_res = 3'($urandom);
                strap_active = 1'($urandom);
                waitc(2);
            end
            if ($urandom % 2 == 0) begin
                do_write(a, d, 1'($urandom));
                check_outputs("R8 R9 outputs after random write");
            end else begin
                do_read(a, "R1 random read");
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule